// File: doc/BRIEF.md
# Back-to-Back Instruction Dependency Checker

This block looks at two instructions that follow each other, the one that has just completed and the one behind it, and decides whether the second one truly depends on the first. A pipeline uses the result to count hazard stalls or to decide whether both instructions may issue in the same cycle. Each instruction arrives as a decoded descriptor, so the block never sees raw opcodes.

The earlier instruction gives a destination. The destination may be absent, a register, or a memory location addressed through a base register. It also gives a condition-flag write bit. The later instruction gives a flag read bit, an optional store address base, and `NSRC` source operands. Each source operand has a kind and a register index. The rules are not symmetric. A flag write followed by a flag read always conflicts. A register result conflicts with any later use of that register, whether the use is direct or as an address base. A store conflicts with any later memory access that reads through a displacement address.

The verdict is registered, so it appears one cycle after the pair is presented. A saturating counter adds one for every dependent pair.

Top module: `insn_dep_checker`

## Requirements
- R1: When `pair_valid` is high, `prv_flag_wr` is 1 and `nxt_flag_rd` is 1, the pair is dependent whatever the operands are.
- R2: When the flag case of R1 does not apply and `prv_dst_vld` is 0, the pair is independent.
- R3: A source operand of kind 2 (immediate) or kind 0 (unused) never causes a dependency, even when its index field equals the earlier destination index.
- R4: When the earlier destination is a register (`prv_dst_vld`=1, `prv_dst_mem`=0), a source of kind 1 (direct register) is dependent exactly when its index equals `prv_dst_idx`.
- R5: When the earlier destination is a register, a source of kind 3 (base plus displacement) is dependent exactly when its base index equals `prv_dst_idx`.
- R6: When the earlier destination is a register and `nxt_dst_mem` is 1, the later store base `nxt_dst_idx` is checked as a source, and the pair is dependent when it equals `prv_dst_idx`. A later register destination (`nxt_dst_mem`=0) is never compared.
- R7: When the earlier destination is memory (`prv_dst_vld`=1, `prv_dst_mem`=1), a later direct-register source or a later store base never causes a dependency, whatever the indices are.
- R8: When the earlier destination is memory, any later source of kind 3 makes the pair dependent, whatever the indices are.
- R9: `dep_out` shows the verdict for the pair sampled at a rising edge, starting right after that edge, and it is 0 after any edge at which `pair_valid` was low.
- R10: `dep_cnt` rises by exactly one at every edge at which a dependent pair is sampled, holds otherwise, and stays at its all-ones value once it gets there.
- R11: A rising edge with `rst_n` low clears `dep_out` and `dep_cnt` to 0.

Source operand j uses bits [2j+1:2j] of `nxt_src_kind` and bits [RW*j+RW-1:RW*j] of `nxt_src_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_valid | input | 1 | A pair is presented this cycle |
| prv_dst_vld | input | 1 | Earlier instruction has a destination |
| prv_dst_mem | input | 1 | Earlier destination is memory, not a register |
| prv_dst_idx | input | RW | Earlier destination register index |
| prv_flag_wr | input | 1 | Earlier instruction writes the condition flag |
| nxt_flag_rd | input | 1 | Later instruction reads the condition flag |
| nxt_dst_mem | input | 1 | Later instruction stores to memory |
| nxt_dst_idx | input | RW | Later store address base register |
| nxt_src_kind | input | 2*NSRC | Later source kinds: 0 unused, 1 register, 2 immediate, 3 base+displacement |
| nxt_src_idx | input | RW*NSRC | Later source register indices |
| dep_out | output | 1 | Registered dependency verdict |
| dep_cnt | output | CW | Saturating count of dependent pairs |

## Verification
The only internal state is the verdict register and the counter. A bad verdict appears on `dep_out` one cycle after the pair, and it also moves `dep_cnt` away from the count the bench expects at that same sample. Because the counter accumulates, a wrong increment, a missed increment or a failure to saturate stays visible at every later sample until reset. A sweep over a 2-bit register space with three sources and a 4-bit counter makes index collisions frequent and reaches saturation within the run.

// File: rtl/dep_pkg.sv
// Package: shared operand-kind encoding for the dependency checker.
// Assumes the decoder that feeds the block uses this same encoding.
package dep_pkg;
    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_REG  = 2'd1,
        OPK_IMM  = 2'd2,
        OPK_DISP = 2'd3
    } opkind_e;
endpackage

// File: rtl/dep_src_cmp.sv
// Module: compares one later source operand with the earlier destination.
// Assumes prv_is_reg and prv_is_mem are never both high.
module dep_src_cmp
    import dep_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [1:0]    kind,
    input  logic [RW-1:0] idx,
    input  logic [RW-1:0] prv_idx,
    input  logic          prv_is_reg,
    input  logic          prv_is_mem,
    output logic          hit
);
    opkind_e k;
    logic    uses_reg;

    // Decode the operand kind and form the per-operand conflict.
    always_comb begin
        k        = opkind_e'(kind);
        uses_reg = (k == OPK_REG) || (k == OPK_DISP);
        hit      = (prv_is_reg && uses_reg && (idx == prv_idx))
                 || (prv_is_mem && (k == OPK_DISP));
    end
endmodule

// File: rtl/dep_pair_eval.sv
// Module: combinational verdict for one instruction pair.
// Assumes the descriptor fields are stable while pair_valid is high.
module dep_pair_eval #(
    parameter int RW   = 5,
    parameter int NSRC = 3
) (
    input  logic              prv_dst_vld,
    input  logic              prv_dst_mem,
    input  logic [RW-1:0]     prv_dst_idx,
    input  logic              prv_flag_wr,
    input  logic              nxt_flag_rd,
    input  logic              nxt_dst_mem,
    input  logic [RW-1:0]     nxt_dst_idx,
    input  logic [2*NSRC-1:0] nxt_src_kind,
    input  logic [RW*NSRC-1:0] nxt_src_idx,
    output logic              dep
);
    logic            prv_is_reg;
    logic            prv_is_mem;
    logic [NSRC-1:0] src_hit;
    logic            base_hit;
    logic            flag_hit;

    // Classify the earlier destination.
    always_comb begin
        prv_is_reg = prv_dst_vld && !prv_dst_mem;
        prv_is_mem = prv_dst_vld &&  prv_dst_mem;
    end

    for (genvar j = 0; j < NSRC; j++) begin : g_src
        dep_src_cmp #(.RW(RW)) u_cmp (
            .kind       (nxt_src_kind[2*j +: 2]),
            .idx        (nxt_src_idx[RW*j +: RW]),
            .prv_idx    (prv_dst_idx),
            .prv_is_reg (prv_is_reg),
            .prv_is_mem (prv_is_mem),
            .hit        (src_hit[j])
        );
    end

    // Store base of the later instruction acts as a register source.
    always_comb begin
        base_hit = prv_is_reg && nxt_dst_mem && (nxt_dst_idx == prv_dst_idx);
        flag_hit = prv_flag_wr && nxt_flag_rd;
        dep      = flag_hit || base_hit || (|src_hit);
    end
endmodule

// File: rtl/dep_counter.sv
// Module: saturating event counter, cleared by synchronous reset.
// Assumes one event at most per clock.
module dep_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Count events, stopping at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && (count != CNT_MAX))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/insn_dep_checker.sv
// Module: top of the back-to-back dependency checker.
// Registers the verdict of dep_pair_eval and counts dependent pairs.
// Assumes a new pair may be presented every cycle.
module insn_dep_checker #(
    parameter int RW   = 5,
    parameter int NSRC = 3,
    parameter int CW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pair_valid,
    input  logic               prv_dst_vld,
    input  logic               prv_dst_mem,
    input  logic [RW-1:0]      prv_dst_idx,
    input  logic               prv_flag_wr,
    input  logic               nxt_flag_rd,
    input  logic               nxt_dst_mem,
    input  logic [RW-1:0]      nxt_dst_idx,
    input  logic [2*NSRC-1:0]  nxt_src_kind,
    input  logic [RW*NSRC-1:0] nxt_src_idx,
    output logic               dep_out,
    output logic [CW-1:0]      dep_cnt
);
    logic dep_comb;
    logic dep_hit;

    dep_pair_eval #(.RW(RW), .NSRC(NSRC)) u_eval (
        .prv_dst_vld  (prv_dst_vld),
        .prv_dst_mem  (prv_dst_mem),
        .prv_dst_idx  (prv_dst_idx),
        .prv_flag_wr  (prv_flag_wr),
        .nxt_flag_rd  (nxt_flag_rd),
        .nxt_dst_mem  (nxt_dst_mem),
        .nxt_dst_idx  (nxt_dst_idx),
        .nxt_src_kind (nxt_src_kind),
        .nxt_src_idx  (nxt_src_idx),
        .dep          (dep_comb)
    );

    // Qualify the verdict with the presence of a pair.
    always_comb dep_hit = pair_valid && dep_comb;

    // Register the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dep_out <= 1'b0;
        else
            dep_out <= dep_hit;
    end

    dep_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (dep_hit),
        .count (dep_cnt)
    );
endmodule

// File: rtl/dep_checker.sv
// Module: temporal properties of insn_dep_checker, attached by bind.
// Assumes the encoding of dep_pkg for source kinds.
module dep_checker #(
    parameter int NSRC = 3,
    parameter int CW   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_valid,
    input logic              prv_dst_vld,
    input logic              prv_dst_mem,
    input logic              prv_flag_wr,
    input logic              nxt_flag_rd,
    input logic [2*NSRC-1:0] nxt_src_kind,
    input logic              dep_out,
    input logic [CW-1:0]     dep_cnt
);
    logic any_disp;
    logic flag_pair;

    // Summarise the later operands for the properties.
    always_comb begin
        any_disp = 1'b0;
        for (int j = 0; j < NSRC; j++)
            if (nxt_src_kind[2*j +: 2] == 2'd3) any_disp = 1'b1;
        flag_pair = prv_flag_wr && nxt_flag_rd;
    end

    AST_FLAG_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && flag_pair) |=> dep_out);  // R1
    AST_NO_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !flag_pair && !prv_dst_vld) |=> !dep_out);  // R2
    AST_STORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && prv_dst_vld && prv_dst_mem && any_disp) |=> dep_out);  // R8
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |=> !dep_out);  // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_out && $past(rst_n) && !(&$past(dep_cnt))) |-> (dep_cnt == $past(dep_cnt) + 1'b1));  // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dep_out && $past(rst_n)) |-> $stable(dep_cnt));  // R10
    AST_RESET_CLR: assert property (@(posedge clk)
        !rst_n |=> (dep_cnt == '0 && !dep_out));  // R11
endmodule

bind insn_dep_checker dep_checker #(.NSRC(NSRC), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_valid   (pair_valid),
    .prv_dst_vld  (prv_dst_vld),
    .prv_dst_mem  (prv_dst_mem),
    .prv_flag_wr  (prv_flag_wr),
    .nxt_flag_rd  (nxt_flag_rd),
    .nxt_src_kind (nxt_src_kind),
    .dep_out      (dep_out),
    .dep_cnt      (dep_cnt)
);

// File: tb/insn_dep_checker_tb.sv
module insn_dep_checker_tb;
    localparam int RW   = 2;
    localparam int NSRC = 3;
    localparam int CW   = 4;
    localparam int NVEC = 3000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pair_valid = 1'b0;
    logic               prv_dst_vld = 1'b0;
    logic               prv_dst_mem = 1'b0;
    logic [RW-1:0]      prv_dst_idx = '0;
    logic               prv_flag_wr = 1'b0;
    logic               nxt_flag_rd = 1'b0;
    logic               nxt_dst_mem = 1'b0;
    logic [RW-1:0]      nxt_dst_idx = '0;
    logic [2*NSRC-1:0]  nxt_src_kind = '0;
    logic [RW*NSRC-1:0] nxt_src_idx = '0;
    logic               dep_out;
    logic [CW-1:0]      dep_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'h1234_abcd;

    always #4 clk = ~clk;

    insn_dep_checker #(.RW(RW), .NSRC(NSRC), .CW(CW)) u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected verdict from the requirements, with the deciding requirement.
    function automatic bit model(output string req);
        bit hit = 0;
        if (prv_flag_wr && nxt_flag_rd) begin req = "R1"; return 1; end
        if (!prv_dst_vld) begin req = "R2"; return 0; end
        if (prv_dst_mem) begin
            req = "R7";
            for (int j = 0; j < NSRC; j++)
                if (nxt_src_kind[2*j +: 2] == 2'd3) begin req = "R8"; hit = 1; end
            return hit;
        end
        req = "R3";
        for (int j = 0; j < NSRC; j++) begin
            if (nxt_src_idx[RW*j +: RW] == prv_dst_idx) begin
                if (nxt_src_kind[2*j +: 2] == 2'd1) begin req = "R4"; hit = 1; end
                if (nxt_src_kind[2*j +: 2] == 2'd3) begin req = "R5"; hit = 1; end
            end
        end
        if (nxt_dst_mem && nxt_dst_idx == prv_dst_idx) begin req = "R6"; hit = 1; end
        return hit;
    endfunction

    // Apply the current pair at a falling edge, then check one cycle later.
    task automatic step(input bit vld, input string tag);
        string req;
        bit    e;
        pair_valid = vld;
        e = vld ? model(req) : 1'b0;
        if (!vld) req = "R9";
        if (tag != "") req = tag;
        @(negedge clk);
        check(req, dep_out, e);
        if (e && exp_cnt < 15) exp_cnt++;
        check("R10", dep_cnt, exp_cnt);
    endtask

    task automatic clear_pair();
        prv_dst_vld = 0; prv_dst_mem = 0; prv_dst_idx = 0; prv_flag_wr = 0;
        nxt_flag_rd = 0; nxt_dst_mem = 0; nxt_dst_idx = 0;
        nxt_src_kind = '0; nxt_src_idx = '0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11", dep_out, 0);
        check("R11", dep_cnt, 0);
        rst_n = 1'b1;

        // R1: flag write then read with no operands
        clear_pair(); prv_flag_wr = 1; nxt_flag_rd = 1; step(1, "R1");
        // R2: no destination, matching register source
        clear_pair(); nxt_src_kind = 6'b000001; step(1, "R2");
        // R3: immediate with matching index field
        clear_pair(); prv_dst_vld = 1; prv_dst_idx = 2; nxt_src_kind = 6'b101000;
        nxt_src_idx = 6'b101010; step(1, "R3");
        // R4: direct match in slot 1, then mismatch
        clear_pair(); prv_dst_vld = 1; prv_dst_idx = 1; nxt_src_kind = 6'b000100;
        nxt_src_idx = 6'b000100; step(1, "R4");
        nxt_src_idx = 6'b000000; step(1, "R4");
        // R5: displacement base match in slot 2
        nxt_src_kind = 6'b110000; nxt_src_idx = 6'b010000; step(1, "R5");
        // R6: store base match, then a register destination is not compared
        nxt_src_kind = '0; nxt_dst_mem = 1; nxt_dst_idx = 1; step(1, "R6");
        nxt_dst_mem = 0; step(1, "R6");
        // R7: earlier store, later direct source and store base with equal index
        clear_pair(); prv_dst_vld = 1; prv_dst_mem = 1; prv_dst_idx = 3;
        nxt_src_kind = 6'b010101; nxt_src_idx = 6'b111111;
        nxt_dst_mem = 1; nxt_dst_idx = 3; step(1, "R7");
        // R8: earlier store, later load with unrelated base
        nxt_dst_mem = 0; nxt_src_kind = 6'b000011; nxt_src_idx = 6'b000000; step(1, "R8");
        // R9: idle cycle with dependent operands on the bus
        prv_flag_wr = 1; nxt_flag_rd = 1; step(0, "R9");

        // Sweep over pseudo-random descriptors (R3..R10 by deciding rule)
        for (int i = 0; i < NVEC; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            prv_dst_vld = lfsr[0] | lfsr[1];
            prv_dst_mem = lfsr[2] & lfsr[3];
            prv_dst_idx = lfsr[5:4];
            prv_flag_wr = lfsr[6] & lfsr[7];
            nxt_flag_rd = lfsr[8];
            nxt_dst_mem = lfsr[9];
            nxt_dst_idx = lfsr[11:10];
            nxt_src_kind = lfsr[17:12];
            nxt_src_idx = lfsr[23:18];
            step(lfsr[24] | lfsr[25], "");
        end

        // R10: counter is saturated after the sweep and holds there
        check("R10", dep_cnt, 15);
        clear_pair(); prv_flag_wr = 1; nxt_flag_rd = 1; step(1, "R1");

        // R11: reset mid-run clears both outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", dep_out, 0);
        check("R11", dep_cnt, 0);
        rst_n = 1'b1; exp_cnt = 0; pair_valid = 0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule